// File: doc/BRIEF.md
# Multi-Mode Program ROM Bank Mapper

This block turns a CPU address in the upper part of the address space into the number of an 8 KB program ROM bank. Software sets it up through six registers: four bank registers, a mode register and an extension register. The mode picks one of three switching granularities: a single 32 KB window, two 16 KB halves, or four 8 KB quarters. It also decides whether the topmost window is tied to a fixed bank or follows bank register 3.

An optional 8 KB window at 0x6000–0x7FFF can also be mapped to ROM. Its bank is derived from bank register 3, scaled to suit the current granularity. A 2-bit outer bank from the extension register always lands in the top two bits of the bank number, so one setup can reach four 512 KB regions.

Register writes are synchronous and take effect from the next clock. Translation is combinational, from the address and the current register contents.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, bank registers 0–3 hold 0xFF and the mode and extension registers hold 0. With these values, address 0x8000 gives bank 0x3C, 0xE000 gives 0x3F, and the 0x6000 window is unmapped.
- R2: A write with wr_sel_i 0..3 loads bank register 0..3, 4 loads the mode register and 5 loads the extension register. The new value applies from the next clock. Codes 6 and 7 change nothing.
- R3: valid_o is 1 for every address at or above 0x8000. It is 1 for 0x6000–0x7FFF only while the window is enabled. Whenever valid_o is 0, bank_o is 0, and every address below 0x6000 gives valid_o 0.
- R4: Whenever valid_o is 1, bank_o[7:6] equals extension register bits 2:1.
- R5: Mode 0 (mode bits 2:0): bank_o[5:0] = 0x0F*4 + address bits 14:13.
- R6: Mode 4: bank_o[5:0] = (reg3 & 0x0F)*4 + address bits 14:13.
- R7: Mode 1: 0x8000–0xBFFF gives bank_o[5:0] = (reg1 & 0x1F)*2 + address bit 13. 0xC000–0xFFFF gives 0x1F*2 + address bit 13.
- R8: Mode 5: as mode 1, except that 0xC000–0xFFFF uses reg3 & 0x1F in place of 0x1F.
- R9: Modes 2 and 3: the quarters at 0x8000, 0xA000 and 0xC000 give reg0, reg1 and reg2 masked to 6 bits. 0xE000 gives 0x3F.
- R10: Modes 6 and 7: as modes 2 and 3, except that 0xE000 gives reg3 & 0x3F.
- R11: In the enabled 0x6000 window, bank_o[5:0] depends on the granularity. In modes 0 and 4 it is (reg3*4+3) & 0x3F. In modes 1 and 5 it is (reg3*2+1) & 0x3F. In the 8 KB modes it is reg3 & 0x3F.
- R12: Mode register bits 6:3 and extension register bits 7:3 and 0 have no effect on any output.
- R13: map6_o equals mode register bit 7. This bit enables the 0x6000 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select (0..3 bank, 4 mode, 5 extension) |
| wr_data_i | input | 8 | Write data |
| addr_i | input | 16 | CPU address |
| bank_o | output | 8 | 8 KB ROM bank number |
| valid_o | output | 1 | Address maps to ROM |
| map6_o | output | 1 | 0x6000 window enabled |

## Verification
The bench builds the block with its default widths: 8-bit registers and bank numbers, four bank registers and a 16-bit address. At these widths the outer bank, the 6-bit masking of the window bank and the wrap of reg3*4+3 all fall on real bit boundaries, so values such as 0xFF and 0x3F in bank register 3 reach every truncation case. Directed sweeps cover all eight modes and all four outer banks in every window. A long run of random writes, including the unused select codes, and random addresses then mixes mode changes with translations cycle by cycle.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_BREG = 4;
  localparam int SEL_W    = 3;
  localparam int ADDR_W   = 16;
  localparam int BANK_W   = 8;
  localparam int OUTER_W  = 2;

  localparam logic [SEL_W-1:0] SEL_MODE = 3'd4;
  localparam logic [SEL_W-1:0] SEL_EXT  = 3'd5;

  typedef enum logic [1:0] {
    GRAN_32K = 2'd0,
    GRAN_16K = 2'd1,
    GRAN_8K  = 2'd2
  } gran_e;

  typedef struct packed {
    gran_e                gran;
    logic                 last_sw;
    logic                 win6_en;
    logic [OUTER_W-1:0]   outer;
  } map_cfg_t;
endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs #(
  parameter int DATA_W   = 8,
  parameter int NUM_BREG = 4,
  parameter int SEL_W    = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [SEL_W-1:0]                  wr_sel_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  output logic [NUM_BREG-1:0][DATA_W-1:0]   breg_o,
  output logic [DATA_W-1:0]                 mode_o,
  output logic [DATA_W-1:0]                 ext_o
);
  import prg_map_pkg::*;

  for (genvar g = 0; g < NUM_BREG; g++) begin : g_breg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) breg_o[g] <= '1;
      else if (wr_en_i && wr_sel_i == SEL_W'(g)) breg_o[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      ext_o  <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_MODE) mode_o <= wr_data_i;
      if (wr_sel_i == SEL_EXT)  ext_o  <= wr_data_i;
    end
  end
endmodule

// File: rtl/prg_map_decode.sv
module prg_map_decode #(
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 2
) (
  input  logic [DATA_W-1:0]         mode_i,
  input  logic [DATA_W-1:0]         ext_i,
  output prg_map_pkg::map_cfg_t     cfg_o
);
  import prg_map_pkg::*;

  logic unused_bits;
  assign unused_bits = ^{mode_i[DATA_W-2:3], ext_i[DATA_W-1:OUTER_W+1], ext_i[0]};

  always_comb begin
    cfg_o = '0;
    if (mode_i[1])      cfg_o.gran = GRAN_8K;
    else if (mode_i[0]) cfg_o.gran = GRAN_16K;
    else                cfg_o.gran = GRAN_32K;
    cfg_o.last_sw = mode_i[2];
    cfg_o.win6_en = mode_i[DATA_W-1];
    cfg_o.outer   = ext_i[OUTER_W:1];
  end
endmodule

// File: rtl/prg_map_xlate.sv
module prg_map_xlate #(
  parameter int DATA_W   = 8,
  parameter int NUM_BREG = 4,
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 8,
  parameter int OUTER_W  = 2
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [NUM_BREG-1:0][DATA_W-1:0]   breg_i,
  input  prg_map_pkg::map_cfg_t             cfg_i,
  output logic [BANK_W-1:0]                 bank_o,
  output logic                              valid_o
);
  import prg_map_pkg::*;

  localparam int LOW_W    = BANK_W - OUTER_W;
  localparam int LAST_IDX = NUM_BREG - 1;

  logic              in_rom, in_win6;
  logic [1:0]        slot;
  logic [LOW_W-1:0]  rom_low, win_low, low;
  logic [DATA_W-1:0] last_reg;
  logic              unused_addr;

  assign unused_addr = ^addr_i[ADDR_W-4:0];
  assign in_rom   = addr_i[ADDR_W-1];
  assign in_win6  = addr_i[ADDR_W-1:ADDR_W-3] == 3'b011;
  assign slot     = addr_i[ADDR_W-2:ADDR_W-3];
  assign last_reg = breg_i[LAST_IDX];

  always_comb begin
    rom_low = '0;
    win_low = '0;
    unique case (cfg_i.gran)
      GRAN_16K: begin
        if (slot[1]) rom_low[LOW_W-1:1] = cfg_i.last_sw ? last_reg[LOW_W-2:0] : '1;
        else         rom_low[LOW_W-1:1] = breg_i[1][LOW_W-2:0];
        rom_low[0] = slot[0];
        win_low    = {last_reg[LOW_W-2:0], 1'b1};
      end
      GRAN_8K: begin
        if (slot == 2'd3) rom_low = cfg_i.last_sw ? last_reg[LOW_W-1:0] : '1;
        else              rom_low = breg_i[slot][LOW_W-1:0];
        win_low = last_reg[LOW_W-1:0];
      end
      default: begin
        rom_low[LOW_W-1:2] = cfg_i.last_sw ? last_reg[LOW_W-3:0] : '1;
        rom_low[1:0]       = slot;
        win_low            = {last_reg[LOW_W-3:0], 2'b11};
      end
    endcase
  end

  assign valid_o = in_rom | (in_win6 & cfg_i.win6_en);
  assign low     = in_rom ? rom_low : win_low;
  assign bank_o  = valid_o ? {cfg_i.outer, low} : '0;
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int DATA_W   = prg_map_pkg::DATA_W,
  parameter int NUM_BREG = prg_map_pkg::NUM_BREG,
  parameter int SEL_W    = prg_map_pkg::SEL_W,
  parameter int ADDR_W   = prg_map_pkg::ADDR_W,
  parameter int BANK_W   = prg_map_pkg::BANK_W,
  parameter int OUTER_W  = prg_map_pkg::OUTER_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              valid_o,
  output logic              map6_o
);
  import prg_map_pkg::*;

  logic [NUM_BREG-1:0][DATA_W-1:0] breg;
  logic [DATA_W-1:0]               mode_q, ext_q;
  map_cfg_t                        cfg;

  prg_map_regs #(.DATA_W(DATA_W), .NUM_BREG(NUM_BREG), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .breg_o(breg), .mode_o(mode_q), .ext_o(ext_q)
  );

  prg_map_decode #(.DATA_W(DATA_W), .OUTER_W(OUTER_W)) u_dec (
    .mode_i(mode_q), .ext_i(ext_q), .cfg_o(cfg)
  );

  prg_map_xlate #(
    .DATA_W(DATA_W), .NUM_BREG(NUM_BREG), .ADDR_W(ADDR_W),
    .BANK_W(BANK_W), .OUTER_W(OUTER_W)
  ) u_xlate (
    .addr_i, .breg_i(breg), .cfg_i(cfg), .bank_o, .valid_o
  );

  assign map6_o = cfg.win6_en;
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  wr_sel_i,
  input logic [15:0] addr_i,
  input logic [7:0]  bank_o,
  input logic        valid_o,
  input logic        map6_o,
  input logic [2:0]  mode_lo_i,
  input logic [1:0]  outer_i
);
  assert_map6_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == 3'd4) |=> $stable(map6_o));

  assert_low_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 16'h6000) |-> (!valid_o && bank_o == 8'h00));

  assert_win6_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:13] == 3'b011 && !map6_o) |-> !valid_o);

  assert_outer_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> bank_o[7:6] == outer_i);

  assert_fixed_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:13] == 3'b111 && mode_lo_i[2:1] == 2'b01) |-> bank_o[5:0] == 6'h3F);

  assert_half_pick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15] && mode_lo_i[1:0] == 2'b01) |-> bank_o[0] == addr_i[13]);
endmodule

bind prg_bank_mapper prg_bank_mapper_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .addr_i(addr_i), .bank_o(bank_o), .valid_o(valid_o), .map6_o(map6_o),
  .mode_lo_i(mode_q[2:0]), .outer_i(ext_q[2:1])
);

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = 0;
  logic [7:0]  wr_data = 0;
  logic [15:0] addr = 0;
  logic [7:0]  bank;
  logic        valid, map6;

  int checks = 0, errors = 0;
  int r[4];
  int mode_m, ext_m;
  bit done = 0;

  always #4 clk = ~clk;

  prg_bank_mapper dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .addr_i(addr), .bank_o(bank), .valid_o(valid), .map6_o(map6)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%h mode=%h act=%h exp=%h", tag, addr, mode_m, act, exp);
    end
  endtask

  // behavioural reference: returns valid<<8 | bank
  function automatic int model(input int a, output string tag);
    int m = mode_m & 7, outer = (ext_m >> 1) & 3, off, b;
    if (a < 'h6000) begin tag = "R3"; return 0; end
    if (a < 'h8000) begin
      if ((mode_m & 'h80) == 0) begin tag = "R3"; return 0; end
      tag = "R11";
      if (m & 2)      b = r[3] & 63;
      else if (m & 1) b = (r[3] * 2 + 1) & 63;
      else            b = (r[3] * 4 + 3) & 63;
      return 256 + outer * 64 + b;
    end
    off = a - 'h8000;
    if (m & 2) begin
      int s = off / 8192;
      tag = (m & 4) ? "R10" : "R9";
      b = (s < 3) ? (r[s] & 63) : ((m & 4) ? (r[3] & 63) : 63);
    end else if (m & 1) begin
      int b16 = (off < 16384) ? (r[1] & 31) : ((m & 4) ? (r[3] & 31) : 31);
      tag = (m & 4) ? "R8" : "R7";
      b = b16 * 2 + (off / 8192) % 2;
    end else begin
      int b32 = (m & 4) ? (r[3] & 15) : 15;
      tag = (m & 4) ? "R6" : "R5";
      b = b32 * 4 + off / 8192;
    end
    return 256 + outer * 64 + b;
  endfunction

  // one clock: drive at negedge, compare before the edge, then update model
  task automatic cyc(input bit we, input int sel, input int d, input int a, input string xtag = "");
    string tag;
    int e;
    @(negedge clk);
    wr_en = we; wr_sel = sel[2:0]; wr_data = d[7:0]; addr = a[15:0];
    #1;
    e = model(a, tag);
    if (xtag != "") tag = xtag;
    check(tag, {23'd0, valid, bank}, e);
    check("R13", int'(map6), (mode_m >> 7) & 1);
    @(posedge clk);
    if (we) begin
      if (sel < 4) r[sel] = d & 255;
      else if (sel == 4) mode_m = d & 255;
      else if (sel == 5) ext_m = d & 255;
    end
  endtask

  task automatic wr(input int sel, input int d);
    cyc(1, sel, d, 'h8000);
  endtask

  task automatic sweep(input string xtag = "");
    for (int a = 'h5000; a <= 'hF000; a += 'h1000) cyc(0, 0, 0, a, xtag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) r[i] = 255;
    mode_m = 0; ext_m = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1: reset contents seen through the ports
    cyc(0, 0, 0, 'h8000, "R1");
    cyc(0, 0, 0, 'hE000, "R1");
    cyc(0, 0, 0, 'h6000, "R1");
    sweep("R1");

    // R2: loads and the next-cycle effect; R12: unused bits
    wr(0, 'h12); wr(1, 'h25); wr(2, 'h3A); wr(3, 'h07);
    for (int m = 0; m < 8; m++) begin
      wr(4, m | 'h80);
      sweep();
      wr(4, m | 'hF8);
      sweep("");
      cyc(0, 0, 0, 'h6000, "R12");
      cyc(0, 0, 0, 'hE000, "R12");
    end
    // R4: every outer bank, plus ignored extension bits
    for (int o = 0; o < 4; o++) begin
      wr(5, o << 1);
      sweep("R4");
      wr(5, (o << 1) | 'hF9);
      sweep("R12");
    end
    // R2: codes 6 and 7 change nothing
    wr(4, 'h86); wr(5, 2);
    cyc(1, 6, 'h00, 'hE000, "R2");
    cyc(1, 7, 'h00, 'h8000, "R2");
    sweep("R2");
    // R11: wrap of bank register 3 in the window
    for (int m = 0; m < 8; m++) begin
      wr(4, 'h80 | m);
      foreach (r[i]) begin
        wr(3, (i == 0) ? 'hFF : (i == 1) ? 'h3F : (i == 2) ? 'h40 : 'h11);
        cyc(0, 0, 0, 'h7FFF, "R11");
        cyc(0, 0, 0, 'hFFFF);
      end
    end
    // R13: window disabled again
    wr(4, 'h05);
    cyc(0, 0, 0, 'h6800, "R13");
    // R5-R10 mixed: random writes and addresses
    for (int n = 0; n < 3000; n++) begin
      int a = 'h4000 + ($urandom % 'hC000);
      if (($urandom % 4) == 0) cyc(1, $urandom % 8, $urandom % 256, a);
      else                     cyc(0, 0, 0, a);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule